// File: doc/BRIEF.md
# GPIO Expander Register and Interrupt Core

This block is the register file and interrupt engine of an eight-pin general-purpose I/O port. A host reaches it through a byte-wide register port with an address, write data, a write strobe, a read strobe and read data. Per-pin bits set the direction, the output level, input inversion and a pull-up request. The input pins are synchronized before the core uses them. Interrupt-on-change logic watches the enabled pins. It compares each one either against a stored reference bit or against its own value from the previous cycle.

When a watched pin trips, the core records the single pin that fired in a flag register. In the same cycle it snapshots the whole port into a capture register. Both stay frozen until the host clears the event. The clear comes from a read of the port register, or from a read of the capture register, as one configuration bit selects. The interrupt pin can be push-pull active-low, push-pull active-high, or open-drain. Serial framing, bus address matching and pad electrical behaviour lie outside the core.

The host port is a plain register interface with no back-pressure. `host_rdata` always shows the register that `host_addr` selects, without delay. A read has a side effect only in a cycle where `host_rd` is high. A write takes effect at the clock edge where `host_wr` is high.

Top module: `gpx_core`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0x00, direction register reads 0xFF). All other registers read 0x00, no event is pending, and the interrupt pin is push-pull active-low and idle (`irq_o` = 1, `irq_oe` = 1).
- R2: The registers at offsets 0x00 direction, 0x01 inversion, 0x02 enable, 0x03 reference, 0x04 mode select, 0x05 configuration, 0x06 pull-up and 0x0A output latch read back exactly the byte last written. All eight configuration bits are kept.
- R3: `pin_oe[i]` is high exactly when direction bit i is 0. `pin_out` equals the output latch. `pull_en` equals the pull-up register. Each follows a write one cycle later.
- R4: A read at 0x09 returns the input pins delayed by two synchronizer flops, XOR the inversion register.
- R5: With mode-select bit i = 0 and enable bit i = 1, a change of the inverted, synchronized value of pin i raises a pending event at the third clock edge after the pin changes.
- R6: With mode-select bit i = 1 and enable bit i = 1, pin i raises an event whenever its inverted, synchronized value differs from reference bit i.
- R7: When several enabled pins trip in the same cycle, the flag register (0x07) holds only the lowest-numbered of them as a one-hot bit. The capture register (0x08) holds the inverted port value of that cycle.
- R8: While an event is pending, later pin activity does not change the flag or capture registers.
- R9: Configuration bit 0 selects the clear source. When it is 0, a strobed read of 0x09 clears the flag register and a read of 0x08 does not. When it is 1, the roles swap.
- R10: If a trip condition holds in the cycle of the clearing read, the event is re-armed at that same edge. A reference-mode pin that still differs therefore stays flagged.
- R11: Configuration bit 2 = 1 makes the interrupt open-drain: `irq_oe` = 1 and `irq_o` = 0 while pending, `irq_oe` = 0 when idle. Otherwise `irq_oe` = 1 and `irq_o` equals configuration bit 1 while pending and its inverse when idle.
- R12: Reads at addresses above 0x0A return 0x00. Writes there, and writes to 0x07, 0x08 and 0x09, change no register.
- R13: A pin whose enable bit is 0 never raises an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W (8) | Register offset |
| host_wdata | input | NPINS (8) | Write data |
| host_wr | input | 1 | Write strobe, one edge per write |
| host_rd | input | 1 | Read strobe, carries clear side effects |
| host_rdata | output | NPINS (8) | Register selected by host_addr |
| pin_in | input | NPINS (8) | Asynchronous pin levels |
| pin_out | output | NPINS (8) | Output latch levels |
| pin_oe | output | NPINS (8) | Per-pin output enable, 1 = drive |
| pull_en | output | NPINS (8) | Per-pin pull-up request |
| irq_o | output | 1 | Interrupt level |
| irq_oe | output | 1 | Interrupt driver enable |

## Verification
The bench goes after several corner cases, each tied to a specific failure:
- Simultaneous trips on two pins. A wrong priority encoder would leave two flag bits set or report the higher pin.
- Pin activity while an event is pending. A core without the freeze would overwrite the snapshot.
- Clearing reads under both settings of the clear-select bit. Reading the wrong register would drop the event early or never release it.
- A reference-mode pin that still differs at the clearing read. Its event must survive; a core that clears unconditionally would lose it.

It also writes and reads out-of-map and read-only addresses. A decode that aliases them would corrupt a live register. A free-running phase of mixed pins, modes and reads is compared cycle by cycle against the behavioural model.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  typedef enum logic [3:0] {
    OFS_DIR  = 4'h0,
    OFS_INV  = 4'h1,
    OFS_IEN  = 4'h2,
    OFS_REF  = 4'h3,
    OFS_SEL  = 4'h4,
    OFS_CFG  = 4'h5,
    OFS_PULL = 4'h6,
    OFS_FLAG = 4'h7,
    OFS_CAP  = 4'h8,
    OFS_PORT = 4'h9,
    OFS_OLAT = 4'hA
  } reg_ofs_e;

  localparam int LAST_OFS   = 10;
  localparam int CFG_CLRSEL = 0;
  localparam int CFG_POL    = 1;
  localparam int CFG_OD     = 2;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d;
      end
      assign q = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  port_val,
  input  logic [NPINS-1:0]  flag_val,
  input  logic [NPINS-1:0]  cap_val,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  inv_q,
  output logic [NPINS-1:0]  ien_q,
  output logic [NPINS-1:0]  ref_q,
  output logic [NPINS-1:0]  sel_q,
  output logic [NPINS-1:0]  pull_q,
  output logic [NPINS-1:0]  olat_q,
  output logic              irq_od,
  output logic              irq_pol,
  output logic              clr_evt
);
  logic [NPINS-1:0] cfg_q;
  logic             in_page;
  reg_ofs_e         ofs;

  assign in_page = ((addr >> 4) == '0);
  assign ofs     = reg_ofs_e'(addr[3:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      inv_q  <= '0;
      ien_q  <= '0;
      ref_q  <= '0;
      sel_q  <= '0;
      cfg_q  <= '0;
      pull_q <= '0;
      olat_q <= '0;
    end else if (wr && in_page) begin
      case (ofs)
        OFS_DIR:  dir_q  <= wdata;
        OFS_INV:  inv_q  <= wdata;
        OFS_IEN:  ien_q  <= wdata;
        OFS_REF:  ref_q  <= wdata;
        OFS_SEL:  sel_q  <= wdata;
        OFS_CFG:  cfg_q  <= wdata;
        OFS_PULL: pull_q <= wdata;
        OFS_OLAT: olat_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (in_page) begin
      case (ofs)
        OFS_DIR:  rdata = dir_q;
        OFS_INV:  rdata = inv_q;
        OFS_IEN:  rdata = ien_q;
        OFS_REF:  rdata = ref_q;
        OFS_SEL:  rdata = sel_q;
        OFS_CFG:  rdata = cfg_q;
        OFS_PULL: rdata = pull_q;
        OFS_FLAG: rdata = flag_val;
        OFS_CAP:  rdata = cap_val;
        OFS_PORT: rdata = port_val;
        OFS_OLAT: rdata = olat_q;
        default:  rdata = '0;
      endcase
    end
  end

  // clear source: port read normally, capture read when selected
  assign clr_evt = rd && in_page &&
                   (((ofs == OFS_PORT) && !cfg_q[CFG_CLRSEL]) ||
                    ((ofs == OFS_CAP)  &&  cfg_q[CFG_CLRSEL]));
  assign irq_od  = cfg_q[CFG_OD];
  assign irq_pol = cfg_q[CFG_POL];
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] port_val,
  input  logic [NPINS-1:0] ien_q,
  input  logic [NPINS-1:0] ref_q,
  input  logic [NPINS-1:0] sel_q,
  input  logic             clr_evt,
  output logic [NPINS-1:0] flag_q,
  output logic [NPINS-1:0] cap_q,
  output logic             pending
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] trip;
  logic [NPINS-1:0] first_hit;
  logic             arm;

  function automatic logic [NPINS-1:0] lowest_one(input logic [NPINS-1:0] v);
    logic [NPINS-1:0] r;
    r = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  assign trip      = ien_q & ((sel_q & (port_val ^ ref_q)) |
                              (~sel_q & (port_val ^ prev_q)));
  assign first_hit = lowest_one(trip);
  assign pending   = |flag_q;
  assign arm       = (!pending || clr_evt) && (|trip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= port_val;
      if (arm) begin
        flag_q <= first_hit;
        cap_q  <= port_val;
      end else if (clr_evt) begin
        flag_q <= '0;
      end
    end
  end
endmodule

// File: rtl/gpx_core.sv
module gpx_core #(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [NPINS-1:0]  host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [NPINS-1:0]  host_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pull_en,
  output logic              irq_o,
  output logic              irq_oe
);
  logic [NPINS-1:0] pin_sync, port_val;
  logic [NPINS-1:0] dir_q, inv_q, ien_q, ref_q, sel_q, pull_q, olat_q;
  logic [NPINS-1:0] irq_flag, irq_cap;
  logic             irq_od, irq_pol, clr_evt, irq_pending;

  gpx_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign port_val = pin_sync ^ inv_q;

  gpx_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr(host_addr), .wdata(host_wdata), .wr(host_wr), .rd(host_rd),
    .rdata(host_rdata),
    .port_val(port_val), .flag_val(irq_flag), .cap_val(irq_cap),
    .dir_q(dir_q), .inv_q(inv_q), .ien_q(ien_q), .ref_q(ref_q),
    .sel_q(sel_q), .pull_q(pull_q), .olat_q(olat_q),
    .irq_od(irq_od), .irq_pol(irq_pol), .clr_evt(clr_evt)
  );

  gpx_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .port_val(port_val), .ien_q(ien_q), .ref_q(ref_q), .sel_q(sel_q),
    .clr_evt(clr_evt),
    .flag_q(irq_flag), .cap_q(irq_cap), .pending(irq_pending)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = olat_q;
  assign pull_en = pull_q;

  // open-drain pulls low only while pending; push-pull drives polarity
  assign irq_oe = irq_od ? irq_pending : 1'b1;
  assign irq_o  = irq_od ? 1'b0 : (irq_pending ? irq_pol : ~irq_pol);
endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [NPINS-1:0]  host_wdata,
  input logic              host_wr,
  input logic [NPINS-1:0]  host_rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  pin_out,
  input logic              irq_oe,
  input logic [NPINS-1:0]  irq_flag,
  input logic [NPINS-1:0]  irq_cap,
  input logic              irq_od,
  input logic              clr_evt
);
  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == ADDR_W'(0)) |=> (pin_oe == ~$past(host_wdata)));

  assert_latch_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == ADDR_W'(gpx_pkg::LAST_OFS)) |=> (pin_out == $past(host_wdata)));

  assert_flag_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_flag));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_flag != '0) && !clr_evt) |=> ($stable(irq_cap) && $stable(irq_flag)));

  assert_out_of_map_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr > ADDR_W'(gpx_pkg::LAST_OFS)) |-> (host_rdata == '0));

  assert_od_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_od && irq_flag == '0) |-> !irq_oe);
endmodule

bind gpx_core gpx_core_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_wr(host_wr), .host_rdata(host_rdata), .pin_oe(pin_oe), .pin_out(pin_out),
  .irq_oe(irq_oe), .irq_flag(irq_flag), .irq_cap(irq_cap), .irq_od(irq_od),
  .clr_evt(clr_evt)
);

// File: tb/gpx_core_tb.sv
module gpx_core_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0, pin_in = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata, pin_out, pin_oe, pull_en;
  logic       irq_o, irq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpx_core u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // behavioural reference model
  logic [7:0] m_dir, m_inv, m_ien, m_ref, m_sel, m_cfg, m_pull, m_olat;
  logic [7:0] m_s1, m_s2, m_prev, m_flag, m_cap;

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] eff, hit;
    bit         clr;
    int         first;
    if (!rst_n) begin
      m_dir <= 8'hFF; m_inv <= 0; m_ien <= 0; m_ref <= 0; m_sel <= 0;
      m_cfg <= 0; m_pull <= 0; m_olat <= 0; m_s1 <= 0; m_s2 <= 0;
      m_prev <= 0; m_flag <= 0; m_cap <= 0;
    end else begin
      eff = m_s2 ^ m_inv;
      hit = 0;
      for (int i = 0; i < 8; i++) begin
        if (m_ien[i]) begin
          if (m_sel[i] && eff[i] != m_ref[i]) hit[i] = 1'b1;
          if (!m_sel[i] && eff[i] != m_prev[i]) hit[i] = 1'b1;
        end
      end
      clr = host_rd && ((host_addr == 8'h09 && !m_cfg[0]) ||
                        (host_addr == 8'h08 &&  m_cfg[0]));
      if ((m_flag == 0 || clr) && hit != 0) begin
        first = -1;
        for (int i = 0; i < 8; i++) if (hit[i] && first < 0) first = i;
        m_flag <= 8'd1 << first;
        m_cap  <= eff;
      end else if (clr) begin
        m_flag <= 0;
      end
      m_prev <= eff;
      m_s1   <= pin_in;
      m_s2   <= m_s1;
      if (host_wr) begin
        case (host_addr)
          8'h00: m_dir  <= host_wdata;
          8'h01: m_inv  <= host_wdata;
          8'h02: m_ien  <= host_wdata;
          8'h03: m_ref  <= host_wdata;
          8'h04: m_sel  <= host_wdata;
          8'h05: m_cfg  <= host_wdata;
          8'h06: m_pull <= host_wdata;
          8'h0A: m_olat <= host_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_dir;
      8'h01: return m_inv;
      8'h02: return m_ien;
      8'h03: return m_ref;
      8'h04: return m_sel;
      8'h05: return m_cfg;
      8'h06: return m_pull;
      8'h07: return m_flag;
      8'h08: return m_cap;
      8'h09: return m_s2 ^ m_inv;
      8'h0A: return m_olat;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic pend;
    if (rst_n && !done) begin
      pend = (m_flag != 0);
      chk(pin_oe, ~m_dir, "R3 pin_oe");
      chk(pin_out, m_olat, "R3 pin_out");
      chk(pull_en, m_pull, "R3 pull_en");
      chk({7'd0, irq_oe}, {7'd0, m_cfg[2] ? pend : 1'b1}, "R11 irq_oe");
      chk({7'd0, irq_o}, {7'd0, m_cfg[2] ? 1'b0 : (pend ? m_cfg[1] : ~m_cfg[1])}, "R11 irq_o");
      if (host_addr > 8'h0A)        chk(host_rdata, exp_rd(host_addr), "R12 rdata");
      else if (host_addr == 8'h09)  chk(host_rdata, exp_rd(host_addr), "R4 rdata");
      else if (host_addr == 8'h07 || host_addr == 8'h08)
                                    chk(host_rdata, exp_rd(host_addr), "R7 rdata");
      else                          chk(host_rdata, exp_rd(host_addr), "R2 rdata");
    end
  end

  task automatic drive(input logic [7:0] a, input logic [7:0] d, input logic w, input logic r);
    @(posedge clk); #(CLK_P/4);
    host_addr = a; host_wdata = d; host_wr = w; host_rd = r;
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    drive(a, d, 1'b1, 1'b0);
    drive(a, 8'h00, 1'b0, 1'b0);
  endtask
  task automatic rd_strobe(input logic [7:0] a);
    drive(a, 8'h00, 1'b0, 1'b1);
    drive(a, 8'h00, 1'b0, 1'b0);
  endtask
  task automatic idle(input int n);
    repeat (n) drive(8'h00, 8'h00, 1'b0, 1'b0);
  endtask
  task automatic set_pins(input logic [7:0] v);
    @(posedge clk); #(CLK_P/4);
    pin_in = v; host_wr = 1'b0; host_rd = 1'b0;
  endtask
  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string tag);
    drive(a, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    chk(host_rdata, exp, tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(posedge clk);
    #(CLK_P/4) rst_n = 1'b1;
    @(negedge clk);
    chk(pin_oe, 8'h00, "R1 pin_oe");
    chk(pin_out, 8'h00, "R1 pin_out");
    chk({7'd0, irq_o}, 8'h01, "R1 irq_o");
    chk({7'd0, irq_oe}, 8'h01, "R1 irq_oe");
    peek(8'h00, 8'hFF, "R1 dir");
    peek(8'h07, 8'h00, "R1 flag");

    wr(8'h01, 8'h5A); peek(8'h01, 8'h5A, "R2 inv"); wr(8'h01, 8'h00);
    wr(8'h03, 8'h33); peek(8'h03, 8'h33, "R2 ref"); wr(8'h03, 8'h00);
    wr(8'h05, 8'h68); peek(8'h05, 8'h68, "R2 cfg"); wr(8'h05, 8'h00);
    wr(8'h00, 8'hA5); wr(8'h0A, 8'h3C); wr(8'h06, 8'h81);
    @(negedge clk);
    chk(pin_oe, 8'h5A, "R3 oe");
    chk(pin_out, 8'h3C, "R3 out");
    chk(pull_en, 8'h81, "R3 pull");
    peek(8'h0A, 8'h3C, "R2 olat");
    wr(8'h00, 8'hFF);

    set_pins(8'h0C); idle(3);
    peek(8'h09, 8'h0C, "R4 plain");
    wr(8'h01, 8'hF0);
    peek(8'h09, 8'hFC, "R4 inverted");
    wr(8'h01, 8'h00);

    wr(8'h04, 8'h00); wr(8'h02, 8'h0F);
    set_pins(8'h08); idle(4);
    peek(8'h07, 8'h04, "R5 flag");
    peek(8'h08, 8'h08, "R5 cap");
    set_pins(8'h0A); idle(4);
    peek(8'h07, 8'h04, "R8 flag frozen");
    peek(8'h08, 8'h08, "R8 cap frozen");
    rd_strobe(8'h09); idle(1);
    peek(8'h07, 8'h00, "R9 port read clears");

    set_pins(8'h06); idle(4);
    peek(8'h07, 8'h04, "R7 lowest pin");
    peek(8'h08, 8'h06, "R7 snapshot");
    rd_strobe(8'h09);

    set_pins(8'h26); idle(4);
    peek(8'h07, 8'h00, "R13 disabled pin");

    wr(8'h02, 8'h01); wr(8'h03, 8'h00); wr(8'h04, 8'h01);
    idle(2);
    peek(8'h07, 8'h00, "R6 equal to ref");
    set_pins(8'h27); idle(4);
    peek(8'h07, 8'h01, "R6 differs from ref");
    rd_strobe(8'h09); idle(1);
    peek(8'h07, 8'h01, "R10 re-armed");
    wr(8'h03, 8'h01); rd_strobe(8'h09);
    peek(8'h07, 8'h00, "R10 released");

    wr(8'h04, 8'h00); wr(8'h05, 8'h01);
    set_pins(8'h26); idle(4);
    rd_strobe(8'h09);
    peek(8'h07, 8'h01, "R9 port read kept");
    rd_strobe(8'h08);
    peek(8'h07, 8'h00, "R9 cap read clears");

    wr(8'h05, 8'h02); @(negedge clk);
    chk({7'd0, irq_o}, 8'h00, "R11 active-high idle");
    set_pins(8'h27); idle(4); @(negedge clk);
    chk({7'd0, irq_o}, 8'h01, "R11 active-high pending");
    wr(8'h05, 8'h04); @(negedge clk);
    chk({7'd0, irq_oe}, 8'h01, "R11 od pending oe");
    chk({7'd0, irq_o}, 8'h00, "R11 od pending low");
    rd_strobe(8'h09); @(negedge clk);
    chk({7'd0, irq_oe}, 8'h00, "R11 od released");
    wr(8'h05, 8'h00);

    wr(8'h0B, 8'h55); wr(8'hFF, 8'h55);
    peek(8'h0B, 8'h00, "R12 oob read");
    peek(8'hFF, 8'h00, "R12 oob read high");
    wr(8'h07, 8'hFF); peek(8'h07, 8'h00, "R12 flag write ignored");
    wr(8'h09, 8'h00); peek(8'h09, 8'h27, "R12 port write ignored");
    peek(8'h00, 8'hFF, "R12 dir untouched");

    // mixed traffic, checked every cycle against the model
    wr(8'h02, 8'hFF); wr(8'h04, 8'hA0); wr(8'h03, 8'h80);
    lfsr = 8'h5B;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (k % 3 == 0) pin_in = lfsr;
      if (k % 50 == 25) wr(8'h05, {7'd0, lfsr[0]});
      drive({4'd0, lfsr[3:0]}, lfsr, 1'b0, lfsr[6]);
    end
    idle(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule